// File: doc/BRIEF.md
# Packed Register-Remap Table Loader

This block holds sixteen 16-bit remap entries. Software-style writes reach them through eight configuration registers. Each register carries two packed entries for a 32-bit datapath, or four for a 64-bit datapath.

Every accepted write loads the entries it covers and zeroes every entry above them. It then starts a rebuild of two decoded lookup tables, one for integer registers and one for floating-point registers. The rebuild first empties both tables. It then walks the entries from index 0 upward, one per clock. It stops at the first all-zero entry or at a visit limit chosen by the privilege level captured with the write.

While the rebuild runs, `busy` is high and `cfg_wr_ready` is low, so a new write waits. Each table has a combinational lookup port indexed by a 5-bit register key.

Top module: `remap_table_loader`

## Requirements
- R1: A write to configuration register n loads data bits 15:0 into entry 2n and bits 31:16 into entry 2n+1.
- R2: With XLEN=64 (the default), the same write also loads bits 47:32 into entry 2n+2 and bits 63:48 into entry 2n+3. Indices past 15 are dropped.
- R3: Every entry above the highest one loaded by the write, up to entry 15, becomes zero.
- R4: Before a rebuild fills anything, both decoded tables are emptied completely. No slot filled by an earlier rebuild survives unless the new walk fills it again.
- R5: The walk visits entries from index 0 upward and stops at the first entry whose 16 bits are all zero. Entries beyond it have no effect on either table.
- R6: The number of entries visited is at most a limit set by the privilege level sampled when the write is accepted. The encodings and defaults are: priv=2'b11 gives LIM_M=16, priv=2'b01 gives LIM_S=12, and any other value gives LIM_U=8.
- R7: The entry layout is regkey[4:0], type[5], isvec[6], elwidth[8:7], regidx[15:9].
  - An entry with type=1 fills the integer table; type=0 fills the floating-point table.
  - It fills the slot given by regkey, copies elwidth, regidx and isvec, and sets active.
  - A later entry with the same key and type overwrites an earlier one.
- R8: `cfg_rd_data` always reads as zero.
- R9: The rebuild handles one entry per clock. After a write is accepted, `busy` is high for E+2 cycles, where E is the number of entries written into the tables.
  - While `busy` is high, `cfg_wr_ready` is low.
  - A write held during that time is applied once ready returns.
- R10: After reset every slot of both tables is inactive with all fields zero, `busy` is low and `cfg_wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_valid | input | 1 | Configuration write request |
| cfg_wr_ready | output | 1 | Write accepted this cycle when high with valid |
| cfg_wr_sel | input | $clog2(NUM_CFG) | Configuration register number |
| cfg_wr_data | input | XLEN | Packed entries to load |
| priv | input | 2 | Privilege level, sampled on an accepted write |
| cfg_rd_data | output | XLEN | Configuration read data (always zero) |
| busy | output | 1 | Rebuild in progress |
| int_key | input | 5 | Integer table lookup key |
| int_active | output | 1 | Integer slot active |
| int_isvec | output | 1 | Integer slot vector flag |
| int_elwidth | output | 2 | Integer slot element width |
| int_regidx | output | 7 | Integer slot target register index |
| fp_key | input | 5 | Floating-point table lookup key |
| fp_active | output | 1 | Floating-point slot active |
| fp_isvec | output | 1 | Floating-point slot vector flag |
| fp_elwidth | output | 2 | Floating-point slot element width |
| fp_regidx | output | 7 | Floating-point slot target register index |

## Verification
The assertions check on every cycle the properties that depend only on local state:
- entries above a write come out zero,
- a clear empties the table,
- the walk ends the cycle after it meets a zero entry and never passes its limit,
- each entry lands only in the table its type names.

Only the bench scenarios can show that the contents of both tables are right end to end. That covers keys orphaned by a rewrite, duplicate keys, the three privilege limits on a fully populated bank, the exact busy length, and a write held through a rebuild.

// File: rtl/remap_pkg.sv
package remap_pkg;
   localparam int ENT_W  = 16;
   localparam int KEY_W  = 5;
   localparam int EW_W   = 2;
   localparam int RIDX_W = 7;

   typedef struct packed {
      logic [RIDX_W-1:0] regidx;
      logic [EW_W-1:0]   elwidth;
      logic              isvec;
      logic              is_int;
      logic [KEY_W-1:0]  regkey;
   } remap_ent_t;

   typedef struct packed {
      logic              active;
      logic              isvec;
      logic [EW_W-1:0]   elwidth;
      logic [RIDX_W-1:0] regidx;
   } lut_ent_t;

   typedef enum logic [1:0] {WK_IDLE, WK_CLEAR, WK_WALK} walk_st_t;

   localparam logic [1:0] PRIV_S = 2'b01;
   localparam logic [1:0] PRIV_M = 2'b11;
endpackage

// File: rtl/remap_entry_bank.sv
module remap_entry_bank
   import remap_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int NENT = 16,
   parameter int NCFG = 8,
   localparam int SEL_W = $clog2(NCFG)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [SEL_W-1:0]            wr_sel,
   input  logic [XLEN-1:0]             wr_data,
   output logic [NENT-1:0][ENT_W-1:0]  ents
);
   localparam int CHUNKS = XLEN / ENT_W;

   if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
      $error("remap_entry_bank: XLEN must be 32 or 64");
   end
   if (NENT != 2 * NCFG) begin : g_bad_depth
      $error("remap_entry_bank: NENT must equal 2*NCFG");
   end

   int unsigned base_i, last_i;
   always_comb begin
      base_i = int'(wr_sel) * 2;
      last_i = base_i + CHUNKS - 1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ents <= '0;
      end else if (wr_en) begin
         for (int unsigned i = 0; i < NENT; i++) begin
            if (i >= base_i && i <= last_i)
               ents[i] <= ENT_W'(wr_data >> ((i - base_i) * ENT_W));
            else if (i > last_i)
               ents[i] <= '0;
         end
      end
   end

   for (genvar g = 0; g < NENT; g++) begin : g_chk
      AST_UPPER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && g > last_i) |=> ents[g] == '0); // R3
   end

   AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ents)); // R9
endmodule

// File: rtl/remap_walker.sv
module remap_walker
   import remap_pkg::*;
#(
   parameter int NENT  = 16,
   parameter int LIM_M = 16,
   parameter int LIM_S = 12,
   parameter int LIM_U = 8,
   localparam int IDX_W = $clog2(NENT + 1),
   localparam int SEL_W = $clog2(NENT)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [1:0]                  priv,
   input  logic [NENT-1:0][ENT_W-1:0]  ents,
   output logic                        busy,
   output logic                        clr,
   output logic                        wr_en,
   output remap_ent_t                  wr_ent
);
   if (LIM_M < 1 || LIM_M > NENT || LIM_S < 1 || LIM_S > NENT ||
       LIM_U < 1 || LIM_U > NENT) begin : g_bad_lim
      $error("remap_walker: privilege limits must lie in 1..NENT");
   end

   walk_st_t          st;
   logic [IDX_W-1:0]  idx, lim_q, lim_d;
   logic [ENT_W-1:0]  cur;

   always_comb begin
      if (priv == PRIV_M)      lim_d = IDX_W'(LIM_M);
      else if (priv == PRIV_S) lim_d = IDX_W'(LIM_S);
      else                     lim_d = IDX_W'(LIM_U);
   end

   assign cur    = (idx < IDX_W'(NENT)) ? ents[idx[SEL_W-1:0]] : '0;
   assign wr_en  = (st == WK_WALK) && (idx < lim_q) && (cur != '0);
   assign wr_ent = remap_ent_t'(cur);
   assign clr    = (st == WK_CLEAR);
   assign busy   = (st != WK_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= WK_IDLE;
         idx   <= '0;
         lim_q <= '0;
      end else begin
         case (st)
            WK_IDLE: if (start) begin
               lim_q <= lim_d;
               st    <= WK_CLEAR;
            end
            WK_CLEAR: begin
               idx <= '0;
               st  <= WK_WALK;
            end
            WK_WALK: begin
               if (wr_en) idx <= idx + 1'b1;
               else       st  <= WK_IDLE;
            end
            default: st <= WK_IDLE;
         endcase
      end
   end

   AST_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (st == WK_WALK && cur == '0) |=> st == WK_IDLE); // R5
   AST_WALK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (st == WK_WALK) |-> idx <= lim_q); // R6
   AST_CLEAR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> st == WK_CLEAR); // R4
   AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start); // R9
endmodule

// File: rtl/remap_lut.sv
module remap_lut
   import remap_pkg::*;
#(
   parameter bit IS_INT = 1'b1,
   localparam int KEYS = 2 ** KEY_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  remap_ent_t       wr_ent,
   input  logic [KEY_W-1:0] lkp_key,
   output lut_ent_t         lkp_val
);
   lut_ent_t         tbl [KEYS];
   logic [KEYS-1:0]  act_vec;
   logic             hit;

   assign hit     = wr_en && (wr_ent.is_int == IS_INT);
   assign lkp_val = tbl[lkp_key];

   for (genvar k = 0; k < KEYS; k++) begin : g_act
      assign act_vec[k] = tbl[k].active;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < KEYS; k++) tbl[k] <= '0;
      end else if (clr) begin
         for (int k = 0; k < KEYS; k++) tbl[k] <= '0;
      end else if (hit) begin
         tbl[wr_ent.regkey] <= '{active: 1'b1, isvec: wr_ent.isvec,
                                 elwidth: wr_ent.elwidth, regidx: wr_ent.regidx};
      end
   end

   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> act_vec == '0); // R4
   AST_TYPE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr && wr_ent.is_int != IS_INT) |=> $stable(act_vec)); // R7
   AST_SLOT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> act_vec[$past(wr_ent.regkey)]); // R7
endmodule

// File: rtl/remap_table_loader.sv
module remap_table_loader
   import remap_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int NUM_ENT = 16,
   parameter int NUM_CFG = 8,
   parameter int LIM_M   = 16,
   parameter int LIM_S   = 12,
   parameter int LIM_U   = 8,
   localparam int SEL_W  = $clog2(NUM_CFG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_valid,
   output logic              cfg_wr_ready,
   input  logic [SEL_W-1:0]  cfg_wr_sel,
   input  logic [XLEN-1:0]   cfg_wr_data,
   input  logic [1:0]        priv,
   output logic [XLEN-1:0]   cfg_rd_data,
   output logic              busy,
   input  logic [KEY_W-1:0]  int_key,
   output logic              int_active,
   output logic              int_isvec,
   output logic [EW_W-1:0]   int_elwidth,
   output logic [RIDX_W-1:0] int_regidx,
   input  logic [KEY_W-1:0]  fp_key,
   output logic              fp_active,
   output logic              fp_isvec,
   output logic [EW_W-1:0]   fp_elwidth,
   output logic [RIDX_W-1:0] fp_regidx
);
   logic                           accept, clr, tw_en;
   logic [NUM_ENT-1:0][ENT_W-1:0]  ents;
   remap_ent_t                     tw_ent;
   logic [KEY_W-1:0]               keys [2];
   lut_ent_t                       vals [2];

   assign cfg_wr_ready = !busy;
   assign accept       = cfg_wr_valid && cfg_wr_ready;
   assign cfg_rd_data  = '0;

   remap_entry_bank #(.XLEN(XLEN), .NENT(NUM_ENT), .NCFG(NUM_CFG)) bank_i (
      .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_sel(cfg_wr_sel),
      .wr_data(cfg_wr_data), .ents(ents));

   remap_walker #(.NENT(NUM_ENT), .LIM_M(LIM_M), .LIM_S(LIM_S), .LIM_U(LIM_U)) walk_i (
      .clk(clk), .rst_n(rst_n), .start(accept), .priv(priv), .ents(ents),
      .busy(busy), .clr(clr), .wr_en(tw_en), .wr_ent(tw_ent));

   assign keys[0] = fp_key;
   assign keys[1] = int_key;

   for (genvar t = 0; t < 2; t++) begin : g_tbl
      remap_lut #(.IS_INT(t == 1)) lut_i (
         .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(tw_en), .wr_ent(tw_ent),
         .lkp_key(keys[t]), .lkp_val(vals[t]));
   end

   assign {int_active, int_isvec, int_elwidth, int_regidx} = vals[1];
   assign {fp_active,  fp_isvec,  fp_elwidth,  fp_regidx}  = vals[0];
endmodule

// File: tb/remap_table_loader_tb.sv
module remap_table_loader_tb_top;
   import remap_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_valid = 1'b0;
   logic        cfg_wr_ready;
   logic [2:0]  cfg_wr_sel = '0;
   logic [63:0] cfg_wr_data = '0;
   logic [1:0]  priv = 2'b11;
   logic [63:0] cfg_rd_data;
   logic        busy;
   logic [4:0]  int_key = '0, fp_key = '0;
   logic        int_active, int_isvec, fp_active, fp_isvec;
   logic [1:0]  int_elwidth, fp_elwidth;
   logic [6:0]  int_regidx, fp_regidx;

   always #4 clk = ~clk;

   remap_table_loader dut_i (.*);

   int vectors = 0, miscompares = 0;

   typedef struct {
      bit         is_int;
      logic [4:0] key;
      lut_ent_t   exp;
      string      tag;
   } sb_item_t;

   sb_item_t sb_q[$];
   event sb_go, sb_done;

   logic [15:0] m_ent [16];
   lut_ent_t    m_int [32];
   lut_ent_t    m_fp  [32];
   int          m_visit;

   task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] mk(int key, bit isint, bit v, int elw, int ridx);
      return {7'(ridx), 2'(elw), v, isint, 5'(key)};
   endfunction

   task automatic model_write(int sel, logic [63:0] data, logic [1:0] pv);
      int base = sel * 2;
      int lim;
      for (int i = 0; i < 16; i++) begin
         if (i >= base && i <= base + 3) m_ent[i] = data[(i-base)*16 +: 16];
         else if (i > base + 3)          m_ent[i] = '0;
      end
      for (int k = 0; k < 32; k++) begin m_int[k] = '0; m_fp[k] = '0; end
      lim = (pv == 2'b11) ? 16 : (pv == 2'b01) ? 12 : 8;
      m_visit = 0;
      for (int i = 0; i < lim; i++) begin
         remap_ent_t e;
         if (m_ent[i] == '0) break;
         e = remap_ent_t'(m_ent[i]);
         if (e.is_int) m_int[e.regkey] = '{1'b1, e.isvec, e.elwidth, e.regidx};
         else          m_fp[e.regkey]  = '{1'b1, e.isvec, e.elwidth, e.regidx};
         m_visit++;
      end
   endtask

   task automatic push_tables(string tag);
      for (int k = 0; k < 32; k++) begin
         sb_q.push_back('{1'b1, 5'(k), m_int[k], tag});
         sb_q.push_back('{1'b0, 5'(k), m_fp[k], tag});
      end
      -> sb_go;
      @(sb_done);
   endtask

   initial begin : monitor
      forever begin
         @(sb_go);
         while (sb_q.size() != 0) begin
            sb_item_t it;
            lut_ent_t act;
            it = sb_q.pop_front();
            @(negedge clk);
            int_key = it.key;
            fp_key  = it.key;
            #1;
            act = it.is_int ? lut_ent_t'({int_active, int_isvec, int_elwidth, int_regidx})
                            : lut_ent_t'({fp_active, fp_isvec, fp_elwidth, fp_regidx});
            check(act == it.exp, it.tag,
                  $sformatf("%s slot %0d", it.is_int ? "int" : "fp", it.key),
                  64'(act), 64'(it.exp));
         end
         -> sb_done;
      end
   end

   task automatic drive(int sel, logic [63:0] data);
      @(negedge clk);
      cfg_wr_sel   = 3'(sel);
      cfg_wr_data  = data;
      cfg_wr_valid = 1'b1;
      while (!cfg_wr_ready) @(negedge clk);
      @(posedge clk);
      #1 cfg_wr_valid = 1'b0;
      model_write(sel, data, priv);
   endtask

   task automatic do_write(int sel, logic [63:0] data, string tag);
      int cnt = 0;
      drive(sel, data);
      @(negedge clk);
      while (busy) begin
         cnt++;
         check(!cfg_wr_ready, "R9", "ready while busy", 64'(cfg_wr_ready), 64'd0);
         @(negedge clk);
      end
      check(cnt == m_visit + 2, "R9", "busy cycles", 64'(cnt), 64'(m_visit + 2));
      check(cfg_rd_data == '0, "R8", "read data", cfg_rd_data, 64'd0);
      push_tables(tag);
   endtask

   function automatic logic [63:0] pack4(logic [15:0] a, logic [15:0] b,
                                         logic [15:0] c, logic [15:0] d);
      return {d, c, b, a};
   endfunction

   initial begin : watchdog
      #(8 * 150000);
      miscompares++;
      $display("FAIL R9 watchdog expired actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin : driver
      for (int i = 0; i < 16; i++) m_ent[i] = '0;
      for (int k = 0; k < 32; k++) begin m_int[k] = '0; m_fp[k] = '0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      check(busy == 1'b0, "R10", "busy after reset", 64'(busy), 64'd0);
      check(cfg_wr_ready == 1'b1, "R10", "ready after reset", 64'(cfg_wr_ready), 64'd1);
      check(cfg_rd_data == '0, "R8", "read data after reset", cfg_rd_data, 64'd0);
      push_tables("R10");

      // R1 R2 R7: four mixed entries through register 0
      priv = 2'b11;
      do_write(0, pack4(mk(3, 1, 1, 2, 40), mk(7, 0, 0, 1, 9),
                        mk(12, 1, 0, 3, 127), mk(7, 0, 1, 0, 1)), "R1");
      // R2: register 1 loads 2..5; entries 0,1 stay
      do_write(1, pack4(mk(20, 0, 1, 2, 5), mk(21, 1, 1, 1, 6),
                        mk(22, 0, 0, 3, 7), mk(23, 1, 0, 0, 8)), "R2");
      // R3 R4: rewrite register 0, entries 4..7 must vanish with their keys
      do_write(2, pack4(mk(24, 1, 0, 1, 11), mk(25, 0, 1, 1, 12),
                        mk(26, 1, 1, 2, 13), mk(27, 0, 0, 2, 14)), "R3");
      do_write(0, pack4(mk(1, 1, 0, 0, 2), mk(2, 0, 0, 0, 3),
                        mk(4, 1, 1, 1, 4), mk(5, 0, 1, 1, 5)), "R4");
      // R5: zero at entry 1 stops the walk; entries 2,3 ignored
      do_write(0, pack4(mk(9, 1, 1, 3, 99), 16'h0000,
                        mk(10, 1, 0, 1, 50), mk(11, 0, 0, 2, 51)), "R5");
      // R7: duplicate key, later entry wins
      do_write(0, pack4(mk(6, 1, 0, 1, 20), mk(6, 1, 1, 2, 21),
                        mk(6, 0, 0, 3, 22), mk(8, 0, 1, 0, 23)), "R7");

      // R6: fill all 16 entries in ascending order under U, then S, then M
      priv = 2'b00;
      for (int s = 0; s < 8; s += 2) begin
         int b = s * 2;
         do_write(s, pack4(mk(b, b % 2, 1, 1, b + 1), mk(b + 1, (b + 1) % 2, 0, 2, b + 2),
                           mk(b + 2, b % 2, 0, 3, b + 3), mk(b + 3, (b + 1) % 2, 1, 0, b + 4)),
                  "R6");
      end
      priv = 2'b01;
      do_write(6, pack4(mk(12, 0, 1, 1, 13), mk(13, 1, 0, 2, 14),
                        mk(14, 0, 0, 3, 15), mk(15, 1, 1, 0, 16)), "R6");
      priv = 2'b10;
      do_write(6, pack4(mk(12, 0, 1, 1, 13), mk(13, 1, 0, 2, 14),
                        mk(14, 0, 0, 3, 15), mk(15, 1, 1, 0, 16)), "R6");
      priv = 2'b11;
      do_write(6, pack4(mk(28, 0, 1, 1, 60), mk(29, 1, 0, 2, 61),
                        mk(30, 0, 0, 3, 62), mk(31, 1, 1, 0, 63)), "R6");

      // R9: a write offered during a rebuild stalls, then is applied
      drive(0, pack4(mk(17, 1, 1, 1, 70), mk(18, 0, 1, 1, 71),
                     mk(19, 1, 0, 2, 72), mk(16, 0, 0, 2, 73)));
      @(negedge clk);
      check(busy && !cfg_wr_ready, "R9", "ready during rebuild",
            64'(cfg_wr_ready), 64'd0);
      do_write(3, pack4(mk(0, 1, 0, 3, 90), mk(31, 0, 1, 3, 91),
                        mk(30, 1, 1, 0, 92), mk(29, 0, 0, 1, 93)), "R9");

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule